// File: doc/BRIEF.md
# Ring-Ordered JTAG Data Router

This block sits between two upstream JTAG controllers and eight die sites placed on a ring. It steers only the serial data pair. Each controller's TDI is threaded through a selected subset of the dice in ring order, and the result returns on that controller's TDO. The clock, mode-select and reset lines of a controller reach its dice without any retiming. Dice are chosen by their location on the ring and not by any identification code. This lets a suspect die be left out of a chain while the dice beyond it stay reachable.

Software loads the routing over a write-only I2C target. Each die site has one byte that holds its include flag, its owning controller and its ring coordinate. A control byte gives each controller a starting coordinate and a walking direction. The staged table takes effect only after an apply request, and only once both controllers have held their mode-select line high for several consecutive TCK rising edges, so that a path never changes in the middle of a scan. A controller whose chain is empty sees its own TDI returned through a single flop clocked on the falling edge of its TCK.

The block samples SCL, SDA, TCK and TMS with a system clock `clk` that must run several times faster than each of them.

Top module: `jtag_ring_router`

## Requirements
- R1: After reset every die site is outside all chains, so each `p_tdi_o` bit is 1, and both controllers are in bypass with `m_tdo_o` reading 1 until their first TCK falling edge.
- R2: The I2C target acknowledges only a write to its 7-bit address `DEV_ADDR` (R/W bit 0), then acknowledges every following byte. For any other address, or when R/W is 1, it drives no acknowledge and no register changes.
- R3: The first byte after the address loads a register pointer, and each later byte writes the register at that pointer and then increments the pointer. Registers 0 to 7 are the site bytes: bit0 include, bit1 owner (0 or 1), bits 7:4 ring coordinate, bits 3:2 ignored. Register 8 is the control byte: bits 2:0 start coordinate and bit3 direction for controller 0, bits 6:4 and bit7 for controller 1. Writing register 9 with bit0 set requests an apply. Other registers are ignored.
- R4: For controller m, the chain visits coordinates start, start+d, start+2d and so on for 8 steps modulo 8, where d is +1 when the direction bit is 0 and -1 when it is 1. At each coordinate the chain takes the lowest-numbered site that is included, owned by m and has that coordinate. A site that is excluded, has a coordinate of 8 or more, or loses a duplicate coordinate is skipped.
- R5: The first site in a chain receives its controller's TDI. Each later site receives the TDO of the site before it. The controller's TDO is the last site's TDO. A site in no chain has its TDI held at 1.
- R6: A controller whose chain is empty returns on `m_tdo_o` the value of its TDI captured at the most recent falling edge of its TCK. The output holds between edges.
- R7: Staged writes have no effect on routing until an apply is requested and both controllers have then seen TMS high on at least `IDLE_TCK` (default 5) consecutive TCK rising edges. A rising edge with TMS low restarts that controller's count.
- R8: Each site's TCK, TMS and TRST outputs follow, without retiming, the controller named by the owner bit of that site's applied byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and configuration |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| m_tck_i | input | 2 | TCK of each controller |
| m_tms_i | input | 2 | TMS of each controller |
| m_trst_n_i | input | 2 | TRST (active low) of each controller |
| m_tdi_i | input | 2 | Serial data from each controller |
| m_tdo_o | output | 2 | Serial data back to each controller |
| p_tck_o | output | 8 | TCK to each die site |
| p_tms_o | output | 8 | TMS to each die site |
| p_trst_n_o | output | 8 | TRST to each die site |
| p_tdi_o | output | 8 | Serial data into each die site |
| p_tdo_i | input | 8 | Serial data out of each die site |

## Verification
A corrupted applied table shows up at once and without any clocking: some `p_tdi_o` bit follows the wrong source, or a controller's `m_tdo_o` tracks the wrong site. The bench therefore drives unique TDO patterns on all sites and compares every data output, for many walk configurations. An early commit shows up as new routing before the fifth idle TCK edge, so the bench checks the old routing after four edges and the new routing after five. A fault in the I2C pointer or in the acknowledge logic changes the acknowledge count or the routing of the following apply.

// File: rtl/jrr_pkg.sv
// Shared constants and types for the ring-ordered JTAG data router.
// Assumes a power-of-two site count so that ring arithmetic wraps naturally.
package jrr_pkg;
    localparam int unsigned JRR_NUM_PORTS   = 8;
    localparam int unsigned JRR_NUM_MASTERS = 2;
    localparam int unsigned JRR_PIDX_W      = $clog2(JRR_NUM_PORTS);
    localparam logic [7:0]  JRR_REG_CTRL    = 8'(JRR_NUM_PORTS);
    localparam logic [7:0]  JRR_REG_APPLY   = 8'(JRR_NUM_PORTS + 1);

    typedef logic [JRR_PIDX_W-1:0] pidx_t;

    // One site byte: coordinate in the top nibble, flags in the low bits.
    typedef struct packed {
        logic [3:0] coord;
        logic [1:0] rsvd;
        logic       owner;
        logic       incl;
    } site_ent_t;

    // Half of the control byte: walking direction above the start coordinate.
    typedef struct packed {
        logic  dir;
        pidx_t start;
    } walk_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } i2c_st_e;
endpackage

// File: rtl/jrr_i2c_wr.sv
// Write-only I2C target. Oversamples SCL/SDA with clk (clk must be several
// times faster than SCL). Emits one write strobe per data byte, with an
// auto-incrementing register pointer loaded by the first byte.
module jrr_i2c_wr
    import jrr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    logic       scl_m, scl_s, scl_d;
    logic       sda_m, sda_s, sda_d;
    logic       scl_rise, scl_fall, bus_start, bus_stop;
    i2c_st_e    st_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    logic [7:0] ptr_q;
    logic       ack_q;

    // Two-stage synchronisers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_d} <= 3'b111;
            {sda_m, sda_s, sda_d} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_d} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_d} <= {sda_i, sda_m, sda_s};
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

    // Byte receiver, acknowledge slot and register pointer handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            ptr_q     <= '0;
            ack_q     <= 1'b0;
            wr_stb_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (bus_start) begin
                st_q  <= ST_ADDR;
                cnt_q <= '0;
                ack_q <= 1'b0;
            end else if (bus_stop) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
                ack_q <= 1'b0;
            end else if (st_q != ST_IDLE && st_q != ST_SKIP) begin
                if (scl_rise && !ack_q && cnt_q < 4'd8) begin
                    sh_q  <= {sh_q[6:0], sda_s};
                    cnt_q <= cnt_q + 4'd1;
                end else if (scl_fall) begin
                    if (ack_q) begin
                        ack_q <= 1'b0;
                        cnt_q <= '0;
                        if (st_q == ST_ADDR)     st_q <= ST_PTR;
                        else if (st_q == ST_PTR) st_q <= ST_DATA;
                    end else if (cnt_q == 4'd8) begin
                        case (st_q)
                            ST_ADDR: begin
                                if (sh_q[7:1] == DEV_ADDR && !sh_q[0]) ack_q <= 1'b1;
                                else                                   st_q  <= ST_SKIP;
                            end
                            ST_PTR: begin
                                ptr_q <= sh_q;
                                ack_q <= 1'b1;
                            end
                            default: begin
                                wr_stb_o  <= 1'b1;
                                wr_addr_o <= ptr_q;
                                wr_data_o <= sh_q;
                                ptr_q     <= ptr_q + 8'd1;
                                ack_q     <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end

    assign sda_oe_o = ack_q;

    AST_ACK_IN_NINTH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> cnt_q == 4'd8);                                        // R2
    AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ptr_q == wr_addr_o + 8'd1);                         // R3
endmodule

// File: rtl/jrr_idle_mon.sv
// Counts consecutive TCK rising edges with TMS high for one controller,
// saturating at IDLE_TCK. TCK and TMS are oversampled by clk.
module jrr_idle_mon #(
    parameter int unsigned IDLE_TCK = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_i,
    input  logic tms_i,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(IDLE_TCK + 1);

    logic          tck_m, tck_s, tck_d, tms_m, tms_s, tck_rise;
    logic [CW-1:0] cnt_q;

    // Synchronise TCK and TMS with matching latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {tck_m, tck_s, tck_d} <= 3'b000;
            {tms_m, tms_s}        <= 2'b00;
        end else begin
            {tck_m, tck_s, tck_d} <= {tck_i, tck_m, tck_s};
            {tms_m, tms_s}        <= {tms_i, tms_m};
        end
    end

    assign tck_rise = tck_s & ~tck_d;

    // Saturating run-length counter of idle-high TCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (tck_rise) begin
            if (!tms_s)                    cnt_q <= '0;
            else if (cnt_q != CW'(IDLE_TCK)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_o = (cnt_q == CW'(IDLE_TCK));

    AST_TMS_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_rise && !tms_s) |=> cnt_q == '0);                           // R7
endmodule

// File: rtl/jrr_cfg_regs.sv
// Staged site table and control byte, apply request, and the applied
// routing table derived from a ring walk at commit time.
module jrr_cfg_regs
    import jrr_pkg::*;
(
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_stb_i,
    input  logic [7:0]                                wr_addr_i,
    input  logic [7:0]                                wr_data_i,
    input  logic                                      idle_all_i,
    output logic [JRR_NUM_PORTS-1:0]                  act_member_o,
    output logic [JRR_NUM_PORTS-1:0]                  act_first_o,
    output logic [JRR_NUM_PORTS-1:0]                  act_owner_o,
    output logic [JRR_NUM_PORTS-1:0][JRR_PIDX_W-1:0]  act_prev_o,
    output logic [JRR_NUM_MASTERS-1:0][JRR_PIDX_W-1:0] act_last_o,
    output logic [JRR_NUM_MASTERS-1:0]                act_empty_o
);
    localparam int unsigned NP = JRR_NUM_PORTS;
    localparam int unsigned NM = JRR_NUM_MASTERS;

    site_ent_t [NP-1:0] map_q;
    walk_cfg_t [NM-1:0] ctrl_q;
    logic               pend_q;
    logic               commit;

    logic [NP-1:0]        nx_member, nx_first;
    logic [NP-1:0][JRR_PIDX_W-1:0] nx_prev;
    logic [NM-1:0][JRR_PIDX_W-1:0] nx_last;
    logic [NM-1:0]        nx_empty;
    logic                 w_have, w_hit;
    pidx_t                w_prev, w_pos, w_idx;

    // Register writes from the I2C target and the apply request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            ctrl_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (commit) pend_q <= 1'b0;
            if (wr_stb_i) begin
                if (wr_addr_i < JRR_REG_CTRL)        map_q[wr_addr_i[JRR_PIDX_W-1:0]] <= wr_data_i;
                else if (wr_addr_i == JRR_REG_CTRL)  ctrl_q <= wr_data_i;
                else if (wr_addr_i == JRR_REG_APPLY && wr_data_i[0]) pend_q <= 1'b1;
            end
        end
    end

    assign commit = pend_q && idle_all_i;

    // Ring walk over the staged table: predecessor of each site, last site per controller.
    always_comb begin
        nx_member = '0;
        nx_first  = '0;
        nx_prev   = '0;
        nx_last   = '0;
        nx_empty  = '1;
        w_have    = 1'b0;
        w_prev    = '0;
        w_pos     = '0;
        w_hit     = 1'b0;
        w_idx     = '0;
        for (int m = 0; m < NM; m++) begin
            w_have = 1'b0;
            w_prev = '0;
            for (int k = 0; k < NP; k++) begin
                w_pos = ctrl_q[m].dir ? ctrl_q[m].start - pidx_t'(k)
                                      : ctrl_q[m].start + pidx_t'(k);
                w_hit = 1'b0;
                w_idx = '0;
                for (int q = NP - 1; q >= 0; q--) begin
                    if (map_q[q].incl && map_q[q].owner == 1'(m) && map_q[q].coord == 4'(w_pos)) begin
                        w_hit = 1'b1;
                        w_idx = pidx_t'(q);
                    end
                end
                if (w_hit) begin
                    nx_member[w_idx] = 1'b1;
                    nx_first[w_idx]  = !w_have;
                    nx_prev[w_idx]   = w_prev;
                    w_have           = 1'b1;
                    w_prev           = w_idx;
                end
            end
            nx_last[m]  = w_prev;
            nx_empty[m] = !w_have;
        end
    end

    // Applied table, replaced only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_member_o <= '0;
            act_first_o  <= '0;
            act_owner_o  <= '0;
            act_prev_o   <= '0;
            act_last_o   <= '0;
            act_empty_o  <= '1;
        end else if (commit) begin
            act_member_o <= nx_member;
            act_first_o  <= nx_first;
            act_prev_o   <= nx_prev;
            act_last_o   <= nx_last;
            act_empty_o  <= nx_empty;
            for (int p = 0; p < NP; p++) act_owner_o[p] <= map_q[p].owner;
        end
    end

    AST_COMMIT_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_member_o, act_owner_o, act_first_o}) |-> $past(idle_all_i)); // R7

    for (genvar gm = 0; gm < NM; gm++) begin : g_chk
        logic [NP-1:0] own_mask;
        for (genvar gp = 0; gp < NP; gp++) begin : g_bit
            assign own_mask[gp] = act_member_o[gp] && (act_owner_o[gp] == 1'(gm));
        end
        AST_EMPTY_MATCHES_MEMBERS: assert property (@(posedge clk) disable iff (!rst_n)
            act_empty_o[gm] == (own_mask == '0));                        // R6
        AST_LAST_IS_OWN_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
            !act_empty_o[gm] |-> own_mask[act_last_o[gm]]);              // R5
    end
endmodule

// File: rtl/jrr_xbar.sv
// Data-path steering from the applied table plus per-controller bypass flops.
// Control lines pass through combinationally from the owning controller.
module jrr_xbar
    import jrr_pkg::*;
(
    input  logic                                       rst_n,
    input  logic [JRR_NUM_PORTS-1:0]                   act_member_i,
    input  logic [JRR_NUM_PORTS-1:0]                   act_first_i,
    input  logic [JRR_NUM_PORTS-1:0]                   act_owner_i,
    input  logic [JRR_NUM_PORTS-1:0][JRR_PIDX_W-1:0]   act_prev_i,
    input  logic [JRR_NUM_MASTERS-1:0][JRR_PIDX_W-1:0] act_last_i,
    input  logic [JRR_NUM_MASTERS-1:0]                 act_empty_i,
    input  logic [JRR_NUM_MASTERS-1:0]                 m_tck_i,
    input  logic [JRR_NUM_MASTERS-1:0]                 m_tms_i,
    input  logic [JRR_NUM_MASTERS-1:0]                 m_trst_n_i,
    input  logic [JRR_NUM_MASTERS-1:0]                 m_tdi_i,
    output logic [JRR_NUM_MASTERS-1:0]                 m_tdo_o,
    output logic [JRR_NUM_PORTS-1:0]                   p_tck_o,
    output logic [JRR_NUM_PORTS-1:0]                   p_tms_o,
    output logic [JRR_NUM_PORTS-1:0]                   p_trst_n_o,
    output logic [JRR_NUM_PORTS-1:0]                   p_tdi_o,
    input  logic [JRR_NUM_PORTS-1:0]                   p_tdo_i
);
    localparam int unsigned NP = JRR_NUM_PORTS;
    localparam int unsigned NM = JRR_NUM_MASTERS;

    logic [NM-1:0] byp;

    for (genvar gm = 0; gm < NM; gm++) begin : g_byp
        logic byp_q;
        // Bypass capture of this controller's TDI on its TCK falling edge.
        always_ff @(negedge m_tck_i[gm]) begin
            if (!rst_n) byp_q <= 1'b1;
            else        byp_q <= m_tdi_i[gm];
        end
        assign byp[gm] = byp_q;
    end

    // Controller return path: last chained site or bypass flop.
    always_comb begin
        for (int m = 0; m < NM; m++)
            m_tdo_o[m] = act_empty_i[m] ? byp[m] : p_tdo_i[act_last_i[m]];
    end

    // Per-site data source and control fan-out.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            p_tck_o[p]    = m_tck_i[act_owner_i[p]];
            p_tms_o[p]    = m_tms_i[act_owner_i[p]];
            p_trst_n_o[p] = m_trst_n_i[act_owner_i[p]];
            if (!act_member_i[p])    p_tdi_o[p] = 1'b1;
            else if (act_first_i[p]) p_tdi_o[p] = m_tdi_i[act_owner_i[p]];
            else                     p_tdi_o[p] = p_tdo_i[act_prev_i[p]];
        end
    end
endmodule

// File: rtl/jtag_ring_router.sv
// Top level: I2C-configured router that threads two JTAG controllers' data
// lines through die sites on a ring. clk must be much faster than SCL and TCK.
module jtag_ring_router
    import jrr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h2C,
    parameter int unsigned IDLE_TCK = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] m_tck_i,
    input  logic [1:0] m_tms_i,
    input  logic [1:0] m_trst_n_i,
    input  logic [1:0] m_tdi_i,
    output logic [1:0] m_tdo_o,
    output logic [7:0] p_tck_o,
    output logic [7:0] p_tms_o,
    output logic [7:0] p_trst_n_o,
    output logic [7:0] p_tdi_o,
    input  logic [7:0] p_tdo_i
);
    localparam int unsigned NP = JRR_NUM_PORTS;
    localparam int unsigned NM = JRR_NUM_MASTERS;

    logic                         wr_stb;
    logic [7:0]                   wr_addr, wr_data;
    logic [NM-1:0]                idle;
    logic [NP-1:0]                act_member, act_first, act_owner;
    logic [NP-1:0][JRR_PIDX_W-1:0] act_prev;
    logic [NM-1:0][JRR_PIDX_W-1:0] act_last;
    logic [NM-1:0]                act_empty;

    jrr_i2c_wr #(.DEV_ADDR(DEV_ADDR)) u_i2c (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    for (genvar gm = 0; gm < NM; gm++) begin : g_idle
        jrr_idle_mon #(.IDLE_TCK(IDLE_TCK)) u_mon (
            .clk(clk), .rst_n(rst_n), .tck_i(m_tck_i[gm]), .tms_i(m_tms_i[gm]), .idle_o(idle[gm])
        );
    end

    jrr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .idle_all_i(&idle),
        .act_member_o(act_member), .act_first_o(act_first), .act_owner_o(act_owner),
        .act_prev_o(act_prev), .act_last_o(act_last), .act_empty_o(act_empty)
    );

    jrr_xbar u_xbar (
        .rst_n(rst_n),
        .act_member_i(act_member), .act_first_i(act_first), .act_owner_i(act_owner),
        .act_prev_i(act_prev), .act_last_i(act_last), .act_empty_i(act_empty),
        .m_tck_i(m_tck_i), .m_tms_i(m_tms_i), .m_trst_n_i(m_trst_n_i), .m_tdi_i(m_tdi_i),
        .m_tdo_o(m_tdo_o), .p_tck_o(p_tck_o), .p_tms_o(p_tms_o), .p_trst_n_o(p_trst_n_o),
        .p_tdi_o(p_tdi_o), .p_tdo_i(p_tdo_i)
    );
endmodule

// File: tb/tb_jtag_ring_router.sv
module tb_jtag_ring_router;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam logic [6:0] ADDR = 7'h2C;

    logic clk = 0, rst_n = 0;
    logic scl = 1, sda_drv = 1;
    logic sda_oe;
    logic [1:0] m_tck = 0, m_tms = 0, m_trst_n = 2'b11, m_tdi = 0, m_tdo;
    logic [7:0] p_tck, p_tms, p_trst_n, p_tdi, p_tdo = 0;
    wire sda_line = sda_drv & ~sda_oe;

    int errors = 0, checks = 0;
    int cur_src[8], cur_last[2], cur_own[8];
    int n_src[8], n_last[2], n_own[8];
    logic [1:0] bp_exp = 2'b11;
    logic [7:0] cfg_map[8];
    logic [7:0] cfg_ctrl;
    logic [7:0] wbuf[12];
    int acks;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_ring_router dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .m_tck_i(m_tck), .m_tms_i(m_tms), .m_trst_n_i(m_trst_n), .m_tdi_i(m_tdi),
        .m_tdo_o(m_tdo), .p_tck_o(p_tck), .p_tms_o(p_tms), .p_trst_n_o(p_trst_n),
        .p_tdi_o(p_tdi), .p_tdo_i(p_tdo)
    );

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr ^ (lfsr >> 13);
    endfunction

    // I2C primitives
    task automatic i2c_start();
        scl = 1; sda_drv = 1; waitc(Q);
        sda_drv = 0; waitc(Q);
        scl = 0; waitc(Q);
    endtask
    task automatic i2c_stop();
        sda_drv = 0; waitc(Q);
        scl = 1; waitc(Q);
        sda_drv = 1; waitc(Q);
    endtask
    task automatic i2c_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            waitc(Q); sda_drv = b[i];
            waitc(Q); scl = 1;
            waitc(2*Q); scl = 0;
        end
        waitc(Q); sda_drv = 1;
        waitc(Q); scl = 1;
        waitc(Q);
        if (!sda_line) acks++;
        waitc(Q); scl = 0;
    endtask
    task automatic i2c_write(input logic [6:0] a, input logic rw, input int n);
        acks = 0;
        i2c_start();
        i2c_byte({a, rw});
        for (int i = 0; i < n; i++) i2c_byte(wbuf[i]);
        i2c_stop();
    endtask

    // One TCK period for both controllers; bypass model captured at the fall.
    task automatic tck_cycle();
        m_tck = 2'b11; waitc(6);
        m_tck = 2'b00; bp_exp = m_tdi; waitc(6);
    endtask

    // Expected chain from R4: walk coordinates, lowest matching site wins.
    task automatic model_cfg();
        for (int p = 0; p < 8; p++) begin
            n_src[p] = -1;
            n_own[p] = cfg_map[p][1];
        end
        for (int m = 0; m < 2; m++) begin
            int st, dir, prev;
            st   = m ? cfg_ctrl[6:4] : cfg_ctrl[2:0];
            dir  = m ? cfg_ctrl[7] : cfg_ctrl[3];
            prev = -1;
            for (int k = 0; k < 8; k++) begin
                int pos, fnd;
                pos = dir ? (st - k + 16) % 8 : (st + k) % 8;
                fnd = -1;
                for (int q = 0; q < 8 && fnd < 0; q++)
                    if (cfg_map[q][0] && cfg_map[q][1] == m[0] && cfg_map[q][7:4] == pos) fnd = q;
                if (fnd >= 0) begin
                    n_src[fnd] = (prev < 0) ? 100 + m : prev;
                    prev = fnd;
                end
            end
            n_last[m] = prev;
        end
    endtask

    task automatic adopt();
        for (int p = 0; p < 8; p++) begin cur_src[p] = n_src[p]; cur_own[p] = n_own[p]; end
        cur_last = n_last;
    endtask

    // Data path against the applied model (R5, R6) under three patterns.
    task automatic check_route(input string req);
        for (int pat = 0; pat < 3; pat++) begin
            logic [31:0] r;
            r = rnd();
            p_tdo = r[7:0];
            m_tdi = r[9:8];
            waitc(2);
            for (int p = 0; p < 8; p++) begin
                int e;
                if (cur_src[p] < 0)        e = 1;
                else if (cur_src[p] >= 100) e = m_tdi[cur_src[p] - 100];
                else                       e = p_tdo[cur_src[p]];
                chk($sformatf("%s p_tdi[%0d]", req, p), p_tdi[p], e);
            end
            for (int m = 0; m < 2; m++) begin
                int e;
                e = (cur_last[m] < 0) ? bp_exp[m] : p_tdo[cur_last[m]];
                chk($sformatf("%s m_tdo[%0d]", req, m), m_tdo[m], e);
            end
        end
    endtask

    // R8: control lines follow the owner bit, no retiming.
    task automatic check_ctrl();
        for (int v = 0; v < 4; v++) begin
            m_tms = v[1:0]; m_trst_n = ~v[1:0];
            waitc(2);
            for (int p = 0; p < 8; p++) begin
                chk("R8 tms", p_tms[p], m_tms[cur_own[p]]);
                chk("R8 trst", p_trst_n[p], m_trst_n[cur_own[p]]);
            end
        end
        m_tck = 2'b01; waitc(2);
        for (int p = 0; p < 8; p++) chk("R8 tck", p_tck[p], m_tck[cur_own[p]]);
        m_tck = 2'b10; bp_exp[0] = m_tdi[0]; waitc(2);
        for (int p = 0; p < 8; p++) chk("R8 tck", p_tck[p], m_tck[cur_own[p]]);
        m_tck = 2'b00; bp_exp[1] = m_tdi[1]; waitc(2);
        m_tms = 2'b11; m_trst_n = 2'b11;
    endtask

    // Full table load with apply gating check (R2, R3, R7) then routing.
    task automatic run_config(input bit interrupt);
        m_tms = 2'b00; tck_cycle();
        for (int i = 0; i < 8; i++) wbuf[i + 1] = cfg_map[i];
        wbuf[0] = 8'd0; wbuf[9] = cfg_ctrl; wbuf[10] = 8'h01;
        i2c_write(ADDR, 1'b0, 11);
        chk("R2 ack count", acks, 12);
        model_cfg();
        check_route("R7 before idle");
        m_tms = 2'b11;
        if (interrupt) begin
            repeat (3) tck_cycle();
            m_tms = 2'b01; tck_cycle();
            m_tms = 2'b11;
        end
        repeat (4) tck_cycle();
        check_route("R7 after four");
        tck_cycle();
        adopt();
        check_route("R4 R5 applied");
    endtask

    initial begin
        for (int p = 0; p < 8; p++) begin cur_src[p] = -1; cur_own[p] = 0; end
        cur_last[0] = -1; cur_last[1] = -1;
        waitc(3);
        tck_cycle();
        waitc(2);
        rst_n = 1;
        bp_exp = 2'b11;
        waitc(2);
        // R1: reset state
        chk("R1 sda_oe", sda_oe, 0);
        for (int i = 0; i < 2; i++) begin
            p_tdo = i ? 8'hFF : 8'h00; m_tdi = i ? 2'b00 : 2'b11; waitc(2);
            chk("R1 p_tdi", p_tdi, 8'hFF);
            chk("R1 m_tdo", m_tdo, 2'b11);
        end
        // R6: bypass holds between edges, captures on the fall
        m_tdi = 2'b01; waitc(3);
        chk("R6 hold", m_tdo, 2'b11);
        tck_cycle();
        chk("R6 capture", m_tdo, 2'b01);
        m_tdi = 2'b10; tck_cycle();
        chk("R6 capture", m_tdo, 2'b10);

        // D1: all sites on controller 0, coordinate = index, clockwise from 0
        for (int p = 0; p < 8; p++) cfg_map[p] = {4'(p), 4'b0001};
        cfg_ctrl = 8'h00;
        run_config(0); check_ctrl();
        // D2: counter-clockwise from 3
        cfg_ctrl = 8'h0B;
        run_config(0);
        // D3: split owners, reversed coordinates, site 2 bad; TMS interruption
        for (int p = 0; p < 8; p++) cfg_map[p] = {4'(7 - p), 2'b10, p[0], (p != 2)};
        cfg_ctrl = 8'hA5;
        run_config(1); check_ctrl();
        // D4: duplicate coordinate and out-of-ring coordinate
        for (int p = 0; p < 8; p++) cfg_map[p] = {4'(p), 4'b0001};
        cfg_map[3] = {4'd2, 4'b0001};
        cfg_map[5] = {4'd9, 4'b0011};
        cfg_ctrl = 8'hC6;
        run_config(0);
        // D5: nothing included, both controllers bypass
        for (int p = 0; p < 8; p++) cfg_map[p] = {4'(p), 4'b0010};
        run_config(0);
        m_tdi = 2'b01; tck_cycle(); waitc(2);
        chk("R6 empty chain", m_tdo, 2'b01);

        // Random sweep
        for (int n = 0; n < 28; n++) begin
            for (int p = 0; p < 8; p++) begin
                logic [31:0] r;
                r = rnd();
                cfg_map[p] = {(r[9] & r[10]) ? {1'b1, r[6:4]} : {1'b0, r[6:4]}, r[3:0]};
                cfg_map[p][0] = r[0] | r[11];
            end
            cfg_ctrl = rnd();
            run_config(n % 7 == 3);
            if (n % 5 == 0) check_ctrl();
        end

        // R3: partial write at pointer 8 flips both directions, apply in same burst
        cfg_ctrl = cfg_ctrl ^ 8'h88;
        m_tms = 2'b00; tck_cycle();
        wbuf[0] = 8'd8; wbuf[1] = cfg_ctrl; wbuf[2] = 8'h01;
        i2c_write(ADDR, 1'b0, 3);
        chk("R3 ack count", acks, 4);
        model_cfg();
        m_tms = 2'b11; repeat (6) tck_cycle();
        adopt();
        check_route("R3 pointer increment");

        // R2: wrong address and read bit are not acknowledged and change nothing
        wbuf[0] = 8'd0;
        for (int i = 1; i < 9; i++) wbuf[i] = 8'h01;
        wbuf[9] = 8'h00; wbuf[10] = 8'h01;
        m_tms = 2'b00; tck_cycle();
        i2c_write(ADDR ^ 7'h01, 1'b0, 11);
        chk("R2 wrong address ack", acks, 0);
        i2c_write(ADDR, 1'b1, 11);
        chk("R2 read ack", acks, 0);
        m_tms = 2'b11; repeat (7) tck_cycle();
        check_route("R2 no effect");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule